// File: doc/BRIEF.md
# Periodic Tick Timer

A 24-bit down-counter with a small word-register interface. Software writes a reload value and then sets the enable bit. The counter loads that value, counts down to zero, and on the next count step it wraps back to the reload value. Each wrap sets a sticky wrap flag and, if the interrupt bit is set, produces a one-cycle interrupt request pulse. The counter steps either on every clock or only on cycles where an external reference tick-enable input is high.

The block sits on a single-cycle register bus with an address, a write strobe, a read strobe, write data and combinational read data. Reading the control word has a side effect: it clears the wrap flag. Writing the current-value word also has a side effect: it reloads the counter. If the reload value is zero when the counter expires, the timer disables itself, so it can act as a one-shot.

Top module: `ptick_timer`

## Requirements
- R1: After reset, every register reads zero, `irq_pulse_o` is low and `wrap_flag_o` is low.
- R2: The control word at offset 0x10 has these fields: bit 0 enables the timer, bit 1 enables the interrupt on wrap, and bit 2 selects the count source. A write changes only bits 2:0. All other bits, including the wrap flag, keep their values.
- R3: A control read returns the wrap flag in bit 16, together with bits 2:0. The flag is cleared on the clock edge that ends the read. If an expiry happens on that same edge, the flag stays set.
- R4: A control write that raises the enable bit loads the reload value into the counter. After that, expiries occur every reload+1 count steps, and the counter reloads after each one.
- R5: When control bit 2 is 1, the counter steps on every clock. When it is 0, the counter steps only on clocks where `ref_tick_i` is high.
- R6: An expiry sets the wrap flag. If control bit 1 is set, the expiry also raises `irq_pulse_o` for exactly one cycle. If bit 1 is clear, no pulse is raised.
- R7: If the reload value is zero at an expiry, control bit 0 clears itself and counting stops.
- R8: A write of any data to the current-value word at offset 0x18 reloads the counter from the reload value and clears the wrap flag.
- R9: The current-value word reads zero while control bit 0 is clear.
- R10: A control write that keeps the timer enabled but changes bit 2 reloads the counter.
- R11: The reload word is at offset 0x14. It and the current value are 24 bits wide: bits above 23 read zero and are ignored on write. The calibration word at offset 0x1C reads the `CAL_WORD` parameter, which defaults to zero. All other offsets read zero.
- R12: In a cycle with a write to the control or current-value word, the counter takes no count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference tick enable, used when control bit 2 is 0 |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, single cycle |
| bus_rd_i | input | 1 | Read strobe, single cycle |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| irq_pulse_o | output | 1 | One-cycle interrupt request on an expiry |
| wrap_flag_o | output | 1 | Sticky wrap flag |

## Verification
The bound checker checks the following on every cycle:
- the pulse always comes with the flag and lasts one cycle;
- each count step lowers a nonzero count by one;
- a current-value write loads the reload value;
- a zero-reload expiry drops the enable bit;
- a control read clears the flag unless an expiry happens on the same edge;
- disabled and out-of-range reads return zeros.

Other properties need the bench's scenarios:
- whole-period lengths;
- the choice of count source;
- the reload on a source change;
- a control write taking priority over a count step;
- the full sequence of a one-shot run.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
  localparam int CTRL_FIELDS   = 3;

  localparam logic [11:0] OFS_CTRL   = 12'h010;
  localparam logic [11:0] OFS_RELOAD = 12'h014;
  localparam logic [11:0] OFS_CUR    = 12'h018;
  localparam logic [11:0] OFS_CAL    = 12'h01C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CUR,
    SEL_CAL
  } reg_sel_e;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;

  // Builds the visible control word from its fields.
  function automatic logic [31:0] f_ctrl_word(input ctrl_t c, input logic flag);
    logic [31:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = c.en;
    w[CTRL_IE_BIT]   = c.ie;
    w[CTRL_SRC_BIT]  = c.src;
    w[CTRL_FLAG_BIT] = flag;
    return w;
  endfunction

endpackage

// File: rtl/ptick_counter.sv
module ptick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // One count step: wrap to the reload value at zero, otherwise decrement.
  function automatic logic [CNT_W-1:0] f_step_value(input logic [CNT_W-1:0] c,
                                                   input logic [CNT_W-1:0] r);
    return (c == ZERO) ? r : (c - ONE);
  endfunction

  logic [CNT_W-1:0] cur_q;

  assign expire_o = step_i && (cur_q == ZERO);
  assign cur_o    = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= ZERO;
    end else if (load_i) begin
      cur_q <= reload_i;
    end else if (step_i) begin
      cur_q <= f_step_value(cur_q, reload_i);
    end
  end

endmodule

// File: rtl/ptick_regfile.sv
module ptick_regfile
  import ptick_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 24,
  parameter logic [31:0] CAL_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cur_i,
  output ctrl_t             ctrl_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ctrl_wr_o,
  output logic              ctrl_rd_o,
  output logic              cur_wr_o,
  output logic              load_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam int               HI_W     = DATA_W - CNT_W;

  reg_sel_e         sel;
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_new;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;
  logic             reload_wr;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] rel_ext;
  logic             unused_wdata_hi;

  // Address decode
  always_comb begin
    sel = SEL_NONE;
    if (addr_i == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_RELOAD)) sel = SEL_RELOAD;
    else if (addr_i == ADDR_W'(OFS_CUR))    sel = SEL_CUR;
    else if (addr_i == ADDR_W'(OFS_CAL))    sel = SEL_CAL;
  end

  assign ctrl_wr_o = wr_i && (sel == SEL_CTRL);
  assign ctrl_rd_o = rd_i && (sel == SEL_CTRL);
  assign reload_wr = wr_i && (sel == SEL_RELOAD);
  assign cur_wr_o  = wr_i && (sel == SEL_CUR);
  assign ctrl_new  = ctrl_t'(wdata_i[CTRL_FIELDS-1:0]);

  // Reload on enable rise, on source change while enabled, or on current write
  assign load_o = cur_wr_o ||
                  (ctrl_wr_o && ctrl_new.en &&
                   (!ctrl_q.en || (ctrl_new.src != ctrl_q.src)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_o) begin
      ctrl_q <= ctrl_new;
    end else if (expire_i && (reload_q == CNT_ZERO)) begin
      ctrl_q.en <= 1'b0;
    end
  end

  // Sticky flag: set by an expiry, which wins over a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire_i) begin
      flag_q <= 1'b1;
    end else if (ctrl_rd_o || cur_wr_o) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= CNT_ZERO;
    end else if (reload_wr) begin
      reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  generate
    if (HI_W > 0) begin : g_ext
      assign cnt_ext         = {{HI_W{1'b0}}, cur_i};
      assign rel_ext         = {{HI_W{1'b0}}, reload_q};
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];
    end else begin : g_noext
      assign cnt_ext         = cur_i[DATA_W-1:0];
      assign rel_ext         = reload_q[DATA_W-1:0];
      assign unused_wdata_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        SEL_CTRL:   rdata_o = DATA_W'(f_ctrl_word(ctrl_q, flag_q));
        SEL_RELOAD: rdata_o = rel_ext;
        SEL_CUR:    rdata_o = ctrl_q.en ? cnt_ext : '0;
        SEL_CAL:    rdata_o = DATA_W'(CAL_WORD);
        default:    rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign reload_o = reload_q;

endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
  import ptick_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 24,
  parameter logic [31:0] CAL_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_pulse_o,
  output logic              wrap_flag_o
);

  ctrl_t            ctrl;
  logic             flag;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cur_q;
  logic             ctrl_wr;
  logic             ctrl_rd;
  logic             cur_wr;
  logic             load;
  logic             step;
  logic             expire;
  logic             irq_q;

  ptick_regfile #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .CAL_WORD(CAL_WORD)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .wdata_i  (bus_wdata_i),
    .expire_i (expire),
    .cur_i    (cur_q),
    .ctrl_o   (ctrl),
    .flag_o   (flag),
    .reload_o (reload_q),
    .rdata_o  (bus_rdata_o),
    .ctrl_wr_o(ctrl_wr),
    .ctrl_rd_o(ctrl_rd),
    .cur_wr_o (cur_wr),
    .load_o   (load)
  );

  // Count-step qualifier: enabled, source tick present, no competing write
  assign step = ctrl.en && (ctrl.src || ref_tick_i) && !ctrl_wr && !cur_wr;

  ptick_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .reload_i(reload_q),
    .cur_o   (cur_q),
    .expire_o(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire && ctrl.ie;
  end

  assign irq_pulse_o = irq_q;
  assign wrap_flag_o = flag;

endmodule

// File: rtl/ptick_timer_chk.sv
module ptick_timer_chk
  import ptick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_pulse_o,
  input logic              wrap_flag_o,
  input logic              en,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  cur_q,
  input logic              step,
  input logic              expire,
  input logic              cur_wr
);

  // R6: a pulse is always accompanied by the flag
  p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> wrap_flag_o);

  // R6: the pulse lasts one cycle
  p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |=> !irq_pulse_o);

  // R4: a step on a nonzero count lowers it by one
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (cur_q != '0)) |=> (cur_q == $past(cur_q) - CNT_W'(1)));

  // R7: an expiry with zero reload drops the enable bit
  p_self_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (reload_q == '0)) |=> !en);

  // R8: a current-value write loads the reload value
  p_cur_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cur_q == $past(reload_q)));

  // R3: a control read clears the flag unless an expiry happens on the same edge
  p_flag_clear_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && (bus_addr_i == ADDR_W'(OFS_CTRL)) && !expire) |=> !wrap_flag_o);

  // R9: the current value reads zero while disabled
  p_idle_cur_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && (bus_addr_i == ADDR_W'(OFS_CUR)) && !en) |-> (bus_rdata_o == '0));

  // R11: reload reads have no bits above the counter width
  p_reload_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && (bus_addr_i == ADDR_W'(OFS_RELOAD))) |->
      ((bus_rdata_o >> CNT_W) == '0));

endmodule

bind ptick_timer ptick_timer_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr_i (bus_addr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_pulse_o(irq_pulse_o),
  .wrap_flag_o(wrap_flag_o),
  .en         (ctrl.en),
  .reload_q   (reload_q),
  .cur_q      (cur_q),
  .step       (step),
  .expire     (expire),
  .cur_wr     (cur_wr)
);

// File: tb/ptick_timer_bench.sv
`timescale 1ns/1ps
module ptick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic [7:0]  addr;
  logic        wr;
  logic        rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        flag;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ptick_timer u_ptick_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick_i (ref_tick),
    .bus_addr_i (addr),
    .bus_wr_i   (wr),
    .bus_rd_i   (rd),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_pulse_o(irq),
    .wrap_flag_o(flag)
  );

  localparam logic [7:0] A_CTRL = 8'h10, A_REL = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  // {is_write, requirement number, address, write data, expected read}
  localparam int NV = 11;
  localparam logic [76:0] VECS [NV] = '{
    {1'b1, 4'd11, A_REL,  32'hFF12_3456, 32'h0},         // R11 upper bits ignored
    {1'b0, 4'd11, A_REL,  32'h0,         32'h0012_3456}, // R11
    {1'b1, 4'd2,  A_CTRL, 32'hFFFF_FFF6, 32'h0},         // R2 only bits 2:0 land
    {1'b0, 4'd2,  A_CTRL, 32'h0,         32'h0000_0006}, // R2
    {1'b0, 4'd9,  A_CUR,  32'h0,         32'h0},         // R9 disabled reads zero
    {1'b0, 4'd11, A_CAL,  32'h0,         32'h0},         // R11 calibration default
    {1'b0, 4'd11, 8'h04,  32'h0,         32'h0},         // R11 unmapped
    {1'b1, 4'd8,  A_CUR,  32'h1234_5678, 32'h0},         // R8 write while idle
    {1'b0, 4'd9,  A_CUR,  32'h0,         32'h0},         // R9
    {1'b1, 4'd2,  A_CTRL, 32'h0,         32'h0},         // R2
    {1'b0, 4'd2,  A_CTRL, 32'h0,         32'h0}          // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  // Called at a falling edge; data sampled combinationally before the next rising edge.
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit saw;
    rst_n = 1'b0; ref_tick = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 flag", {31'b0, flag}, 32'h0);
    read_check("R1 ctrl", A_CTRL, 32'h0);
    read_check("R1 reload", A_REL, 32'h0);
    read_check("R1 cur", A_CUR, 32'h0);

    // Register vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][76]) bus_write(VECS[i][71:64], VECS[i][63:32]);
      else read_check($sformatf("R%0d vec%0d", VECS[i][75:72], i), VECS[i][71:64], VECS[i][31:0]);
    end

    // R4 R6 period with interrupt, fast source
    bus_write(A_REL, 32'd4);
    bus_write(A_CTRL, 32'h7);
    n = 0;
    while (!irq && n < 20) begin @(negedge clk); n++; end
    check("R4 first period", n, 32'd5);
    check("R6 flag on expiry", {31'b0, flag}, 32'h1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, irq}, 32'h0);
    n = 1;
    while (!irq && n < 20) begin @(negedge clk); n++; end
    check("R4 periodic", n, 32'd5);
    read_check("R3 flag in bit16", A_CTRL, 32'h0001_0007);
    read_check("R3 flag cleared", A_CTRL, 32'h0000_0007);
    bus_write(A_CTRL, 32'h0);

    // R12 control write blocks the step
    bus_write(A_REL, 32'd5);
    bus_write(A_CTRL, 32'h5);
    read_check("R4 load on enable", A_CUR, 32'd5);
    bus_write(A_CTRL, 32'h5);
    read_check("R12 no step during write", A_CUR, 32'd4);
    bus_write(A_CTRL, 32'h0);

    // R6 no pulse without interrupt enable; R2 write keeps flag
    bus_write(A_REL, 32'd2);
    bus_write(A_CTRL, 32'h5);
    saw = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); saw |= irq; end
    check("R6 no pulse when bit1 clear", {31'b0, saw}, 32'h0);
    check("R6 flag set", {31'b0, flag}, 32'h1);
    bus_write(A_CTRL, 32'h0);
    read_check("R2 write preserves flag", A_CTRL, 32'h0001_0000);

    // R5 external source, R10 source change reload
    bus_write(A_REL, 32'd3);
    bus_write(A_CTRL, 32'h1);
    repeat (6) @(negedge clk);
    read_check("R5 no step without ref tick", A_CUR, 32'd3);
    ref_tick = 1'b1;
    repeat (2) @(negedge clk);
    ref_tick = 1'b0;
    read_check("R5 steps on ref tick", A_CUR, 32'd1);
    bus_write(A_CTRL, 32'h5);
    read_check("R10 reload on source change", A_CUR, 32'd3);
    bus_write(A_CTRL, 32'h0);

    // R8 current write reloads and clears flag
    bus_write(A_REL, 32'd2);
    bus_write(A_CTRL, 32'h5);
    repeat (5) @(negedge clk);
    check("R8 flag before", {31'b0, flag}, 32'h1);
    bus_write(A_CUR, 32'h00AB_CDEF);
    read_check("R8 reload", A_CUR, 32'd2);
    read_check("R8 flag cleared", A_CTRL, 32'h5);
    bus_write(A_CTRL, 32'h0);

    // R7 self-disable on zero reload; R3 expiry wins over read clear
    bus_write(A_REL, 32'd0);
    bus_write(A_CTRL, 32'h5);
    read_check("R7 still enabled", A_CTRL, 32'h5);
    read_check("R7 disabled with flag", A_CTRL, 32'h0001_0004);
    read_check("R9 cur after self-disable", A_CUR, 32'h0);
    repeat (3) @(negedge clk);
    check("R7 flag clear after read", {31'b0, flag}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule